// File: doc/BRIEF.md
# Credit-Based Transmit Shaper

This block paces one transmit queue that carries audio/video class traffic. It keeps a signed credit balance. The balance grows at a programmed idle rate while a frame waits and shrinks at a programmed send rate while the queue is on the wire. An upper and a lower limit bound the balance, and it drops back to zero when the queue drains with a surplus. The queue arbiter reads a single eligibility output and lets the queue start a new frame only when the balance is not negative.

All four rate and limit inputs are 32-bit fixed-point values scaled by 1024. Software prepares them, folding in a speed factor of 4 at 100 Mb/s or 8 at 1 Gb/s. The `tick` input marks one rate interval, which can be one clock or one byte time. A queue index parameter selects the variant. Queue 0 is never shaped, so its instance holds the balance at zero and is always eligible. When `shaper_on` is low, a shaped queue falls back to plain priority scheduling in the same way.

Top module: `cbs_shaper`

## Requirements
- R1: After reset, `credit` is 0 and `eligible` is 1.
- R2: On a tick with `shaper_on`=1, `queue_pending`=1 and `transmitting`=0, `credit` becomes credit+`idle_slope`, saturated at `hi_credit`. The new value is visible after the next rising clock edge.
- R3: On a tick with `shaper_on`=1 and `transmitting`=1, `credit` becomes credit-`send_slope`, saturated at minus `lo_credit`. `transmitting` has priority over `queue_pending`.
- R4: With `shaper_on`=1 and both `queue_pending` and `transmitting` at 0, a positive credit is cleared to 0 at the next clock edge, whether or not a tick occurs.
- R5: With `shaper_on`=1 and both `queue_pending` and `transmitting` at 0, a negative credit rises by `idle_slope` on each tick but never goes above 0.
- R6: With `shaper_on`=1, a cycle without a tick leaves `credit` unchanged, except for the clearing described in R4.
- R7: With `shaper_on`=1, `eligible` is 1 exactly when `credit` is 0 or greater. It is a direct function of the stored credit and does not wait for another clock edge.
- R8: With `shaper_on`=0, `credit` is forced to 0 at the next edge and `eligible` is 1 at once.
- R9: An instance built with `QUEUE_ID`=0 ignores `shaper_on`. Its `credit` stays 0 and its `eligible` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One rate interval elapsed |
| shaper_on | input | 1 | 1 selects shaped mode, 0 selects priority mode |
| queue_pending | input | 1 | Queue holds at least one frame |
| transmitting | input | 1 | Queue is sending a frame |
| idle_slope | input | PARAM_W | Credit gained per tick while waiting |
| send_slope | input | PARAM_W | Credit lost per tick while sending (magnitude) |
| hi_credit | input | PARAM_W | Upper credit limit |
| lo_credit | input | PARAM_W | Magnitude of the lower credit limit |
| credit | output | PARAM_W+1 | Signed credit balance |
| eligible | output | 1 | Queue may start a frame |

## Verification
The clocked checks assume that the four programmed values stay constant while shaping is active. They also assume that the balance starts and remains between minus the low limit and the high limit, because it starts at zero and those values are never changed mid-run. The stimulus sets the rates and limits once, before `shaper_on` is raised, and changes them only while shaping is off. Inside that window the stimulus drives the pending, transmitting and tick inputs freely, including both flags high together.

// File: rtl/cbs_pkg.sv
package cbs_pkg;
   // Which credit rule applies in a cycle, in priority order
   typedef enum logic [1:0] {
      PH_OFF   = 2'd0,   // priority mode or unshaped queue
      PH_SEND  = 2'd1,   // frame on the wire
      PH_WAIT  = 2'd2,   // frame queued, link held by others
      PH_DRAIN = 2'd3    // nothing queued
   } cbs_phase_e;
endpackage

// File: rtl/cbs_phase_dec.sv
module cbs_phase_dec
   import cbs_pkg::*;
#(
   parameter bit SHAPED = 1'b1
) (
   input  logic       on_i,
   input  logic       pend_i,
   input  logic       tx_i,
   output cbs_phase_e phase_o
);
   generate
      if (SHAPED) begin : g_shaped
         always_comb begin
            if (!on_i)        phase_o = PH_OFF;
            else if (tx_i)    phase_o = PH_SEND;
            else if (pend_i)  phase_o = PH_WAIT;
            else              phase_o = PH_DRAIN;
         end
      end else begin : g_fixed
         logic unused_in;
         assign unused_in = on_i ^ pend_i ^ tx_i;
         assign phase_o   = PH_OFF;
      end
   endgenerate
endmodule

// File: rtl/cbs_credit_step.sv
module cbs_credit_step
   import cbs_pkg::*;
#(
   parameter int PARAM_W = 32
) (
   input  cbs_phase_e                 phase_i,
   input  logic                       tick_i,
   input  logic signed [PARAM_W:0]    cur_i,
   input  logic        [PARAM_W-1:0]  idle_i,
   input  logic        [PARAM_W-1:0]  send_i,
   input  logic        [PARAM_W-1:0]  hi_i,
   input  logic        [PARAM_W-1:0]  lo_i,
   output logic signed [PARAM_W:0]    nxt_o
);
   localparam int CRED_W = PARAM_W + 1;
   localparam int SUM_W  = PARAM_W + 2;

   logic signed [SUM_W-1:0] cur_x, idle_x, send_x, hi_x, floor_x;
   logic signed [SUM_W-1:0] up_x, dn_x, nxt_x;

   assign cur_x   = {cur_i[CRED_W-1], cur_i};
   assign idle_x  = {2'b00, idle_i};
   assign send_x  = {2'b00, send_i};
   assign hi_x    = {2'b00, hi_i};
   assign floor_x = -$signed({2'b00, lo_i});
   assign up_x    = cur_x + idle_x;
   assign dn_x    = cur_x - send_x;

   always_comb begin
      nxt_x = cur_x;
      unique case (phase_i)
         PH_OFF:  nxt_x = '0;
         PH_SEND: if (tick_i) nxt_x = (dn_x < floor_x) ? floor_x : dn_x;
         PH_WAIT: if (tick_i) nxt_x = (up_x > hi_x) ? hi_x : up_x;
         PH_DRAIN: begin
            if (cur_x > 0)
               nxt_x = '0;
            else if (tick_i && cur_x < 0)
               nxt_x = (up_x > 0) ? '0 : up_x;
         end
         default: nxt_x = '0;
      endcase
   end

   // Bounded results always fit in the credit width
   assign nxt_o = nxt_x[CRED_W-1:0];

   logic unused_top;
   assign unused_top = nxt_x[SUM_W-1];
endmodule

// File: rtl/cbs_gate.sv
module cbs_gate #(
   parameter int PARAM_W = 32,
   parameter bit SHAPED  = 1'b1
) (
   input  logic                    on_i,
   input  logic signed [PARAM_W:0] credit_i,
   output logic                    elig_o
);
   generate
      if (SHAPED) begin : g_shaped
         assign elig_o = !on_i || !credit_i[PARAM_W];
      end else begin : g_fixed
         logic unused_in;
         assign unused_in = on_i ^ (^credit_i);
         assign elig_o    = 1'b1;
      end
   endgenerate
endmodule

// File: rtl/cbs_shaper.sv
module cbs_shaper
   import cbs_pkg::*;
#(
   parameter int PARAM_W    = 32,
   parameter int NUM_QUEUES = 8,
   parameter int QUEUE_ID   = 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       tick,
   input  logic                       shaper_on,
   input  logic                       queue_pending,
   input  logic                       transmitting,
   input  logic        [PARAM_W-1:0]  idle_slope,
   input  logic        [PARAM_W-1:0]  send_slope,
   input  logic        [PARAM_W-1:0]  hi_credit,
   input  logic        [PARAM_W-1:0]  lo_credit,
   output logic signed [PARAM_W:0]    credit,
   output logic                       eligible
);
   localparam int CRED_W = PARAM_W + 1;
   localparam bit SHAPED = (QUEUE_ID != 0);

   generate
      if (PARAM_W < 4 || PARAM_W > 62) begin : g_bad_width
         $error("cbs_shaper: PARAM_W out of range");
      end
      if (QUEUE_ID < 0 || QUEUE_ID >= NUM_QUEUES) begin : g_bad_queue
         $error("cbs_shaper: QUEUE_ID out of range");
      end
   endgenerate

   cbs_phase_e              phase;
   logic signed [CRED_W-1:0] credit_nxt;

   cbs_phase_dec #(.SHAPED(SHAPED)) phase_i (
      .on_i   (shaper_on),
      .pend_i (queue_pending),
      .tx_i   (transmitting),
      .phase_o(phase)
   );

   cbs_credit_step #(.PARAM_W(PARAM_W)) step_i (
      .phase_i(phase),
      .tick_i (tick),
      .cur_i  (credit),
      .idle_i (idle_slope),
      .send_i (send_slope),
      .hi_i   (hi_credit),
      .lo_i   (lo_credit),
      .nxt_o  (credit_nxt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) credit <= '0;
      else        credit <= credit_nxt;
   end

   cbs_gate #(.PARAM_W(PARAM_W), .SHAPED(SHAPED)) gate_i (
      .on_i    (shaper_on),
      .credit_i(credit),
      .elig_o  (eligible)
   );

   logic signed [CRED_W-1:0] hi_s, floor_s;
   assign hi_s    = $signed({1'b0, hi_credit});
   assign floor_s = -$signed({1'b0, lo_credit});

   AST_WAIT_RISES: assert property (@(posedge clk) disable iff (!rst_n)
      (SHAPED && shaper_on && tick && queue_pending && !transmitting && credit <= hi_s)
      |=> (credit >= $past(credit) && credit <= $past(hi_s))); // R2
   AST_SEND_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
      (SHAPED && shaper_on && tick && transmitting && credit >= floor_s)
      |=> (credit <= $past(credit) && credit >= $past(floor_s))); // R3
   AST_DRAIN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (shaper_on && !queue_pending && !transmitting && credit > 0) |=> (credit == 0)); // R4
   AST_DRAIN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      (shaper_on && !queue_pending && !transmitting && credit <= 0) |=> (credit <= 0)); // R5
   AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (shaper_on && !tick && (queue_pending || transmitting)) |=> $stable(credit)); // R6
   AST_ELIG_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
      (SHAPED && shaper_on) |-> (eligible == (credit >= 0))); // R7
   AST_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (!shaper_on) |=> (credit == 0)); // R8
   AST_FIXED_QUEUE: assert property (@(posedge clk) disable iff (!rst_n)
      (!SHAPED) |-> (eligible && credit == 0)); // R9
endmodule

// File: tb/cbs_shaper_tb.sv
module cbs_shaper_tb_top;
   localparam int PW = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b0, on = 1'b0, pend = 1'b0, tx = 1'b0;
   logic [PW-1:0] idle = '0, send = '0, hi = '0, lo = '0;
   logic signed [PW:0] credit, credit_q0;
   logic eligible, eligible_q0;

   int total = 0;
   int bad = 0;
   bit done = 0;
   longint mcred = 0;

   typedef struct { longint cred; bit elig; string req; } exp_t;
   exp_t sb[$];

   always #4 clk = ~clk;

   cbs_shaper #(.PARAM_W(PW), .QUEUE_ID(1)) dut_i (
      .clk(clk), .rst_n(rst_n), .tick(tick), .shaper_on(on),
      .queue_pending(pend), .transmitting(tx),
      .idle_slope(idle), .send_slope(send), .hi_credit(hi), .lo_credit(lo),
      .credit(credit), .eligible(eligible));

   cbs_shaper #(.PARAM_W(PW), .QUEUE_ID(0)) dut_q0_i (
      .clk(clk), .rst_n(rst_n), .tick(tick), .shaper_on(on),
      .queue_pending(pend), .transmitting(tx),
      .idle_slope(idle), .send_slope(send), .hi_credit(hi), .lo_credit(lo),
      .credit(credit_q0), .eligible(eligible_q0));

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Driver: apply one cycle of inputs, push the expected state after the next edge
   task automatic step(input bit t, input bit p, input bit x, input bit o, input string req);
      string r;
      @(negedge clk);
      tick = t; pend = p; tx = x; on = o;
      r = req;
      if (!o) mcred = 0;
      else if (x) begin
         if (t) mcred = (mcred - longint'(send) < -longint'(lo)) ? -longint'(lo) : mcred - longint'(send);
      end else if (p) begin
         if (t) mcred = (mcred + longint'(idle) > longint'(hi)) ? longint'(hi) : mcred + longint'(idle);
      end else begin
         if (mcred > 0) mcred = 0;
         else if (t && mcred < 0) mcred = (mcred + longint'(idle) > 0) ? 0 : mcred + longint'(idle);
      end
      sb.push_back('{mcred, (!o) || (mcred >= 0), r});
   endtask

   // Monitor: compare after every edge, away from it
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (rst_n) begin
            check(credit_q0 == 0 && eligible_q0 == 1'b1, "R9 queue0", longint'(credit_q0), 0);
            if (sb.size() > 0) begin
               exp_t e;
               e = sb.pop_front();
               check(longint'(credit) == e.cred, e.req, longint'(credit), e.cred);
               check(eligible == e.elig, {e.req, " R7 eligible"}, longint'(eligible), longint'(e.elig));
            end
         end
      end
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      idle = 700; send = 1300; hi = 3000; lo = 5000;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk); #2;
      check(credit == 0, "R1 credit", longint'(credit), 0);
      check(eligible == 1'b1, "R1 eligible", longint'(eligible), 1);

      // R2: rise while waiting, clamp at hi
      for (int i = 0; i < 5; i++) step(1, 1, 0, 1, "R2 wait rise");
      // R6: no tick holds
      for (int i = 0; i < 3; i++) step(0, 1, 0, 1, "R6 hold");
      // R3: fall while sending, clamp at -lo; tx wins over pending
      for (int i = 0; i < 4; i++) step(1, 1, 1, 1, "R3 send fall");
      for (int i = 0; i < 4; i++) step(1, 0, 1, 1, "R3 send floor");
      step(0, 0, 1, 1, "R6 hold send");
      // R5: negative recovers when empty, capped at 0
      for (int i = 0; i < 9; i++) step(1, 0, 0, 1, "R5 drain rise");
      step(1, 0, 0, 1, "R5 stays zero");
      // R4: positive cleared when empty, even without tick
      step(1, 1, 0, 1, "R2 small rise");
      step(1, 1, 0, 1, "R2 small rise");
      step(0, 0, 0, 1, "R4 clear");
      // R8: priority mode
      step(1, 1, 1, 1, "R3 go negative");
      step(1, 1, 1, 1, "R3 go negative");
      step(0, 1, 1, 0, "R8 off");
      step(1, 1, 0, 0, "R8 off stays");
      // Mixed patterns
      for (int i = 0; i < 400; i++) begin
         int v;
         v = $urandom;
         step(v[0], v[1], v[2] & v[3], (v[7:4] != 0), "R2 R3 R4 R5 mixed");
      end
      // Change limits while off, then use them
      step(0, 0, 0, 0, "R8 off");
      idle = 100000; send = 40000; hi = 250000; lo = 90000;
      for (int i = 0; i < 4; i++) step(1, 1, 0, 1, "R2 new hi");
      for (int i = 0; i < 12; i++) step(1, 0, 1, 1, "R3 new floor");
      repeat (3) @(negedge clk);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule